// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block walks a DDR2 memory through its power-up ritual once the controller leaves reset. After a start pulse it presents a fixed series of memory commands, one at a time, to a downstream command issue unit. Between commands it inserts two timed pauses. A long pause comes after the first no-operation, and a short pause lets the device's delay-locked loop settle after the extended mode registers are written. Each command carries a command code, the bank-address bits that select which mode register is meant, and two payload flags: the DLL-reset bit and the off-chip-driver calibration setting.

The downstream unit owns the real bus timing. It acknowledges each command with a one-cycle `cmd_done` pulse, and the sequencer advances exactly one step per pulse. Pause lengths come from the clock-frequency parameter and are rounded to whole cycles.

When the last command, the return to normal operation, is acknowledged, the sequencer raises `init_done`. It then presents the refresh interval in clock cycles, for use by the refresh scheduler.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low, and until the first start pulse after it, `busy`, `cmd_valid`, `init_done` and `refresh_count` are all 0.
- R2: A `start` pulse in the idle state raises `busy` and `cmd_valid` on the next cycle, and the first command is a no-operation (code 1). Command codes are: normal=0, no-operation=1, all-bank precharge=2, mode register set=3, auto-refresh=4, extended mode register set=5.
- R3: A presented command (code, bank, DLL flag, calibration field) stays unchanged with `cmd_valid` high until `cmd_done` is seen, and each `cmd_done` pulse advances exactly one step. A `cmd_done` pulse while `cmd_valid` is low has no effect.
- R4: After the first no-operation is acknowledged, `cmd_valid` stays low for exactly round((CLK_FREQ_HZ/1000)·200/1000) cycles. A second no-operation then follows.
- R5: Next come the following, in this order: precharge; extended mode set with bank 2, then bank 3, then bank 1; then a pause of exactly round((CLK_FREQ_HZ/1000)·2/1000) cycles with `cmd_valid` low.
- R6: Next comes mode register set on bank 0 with the DLL flag at 1. It is followed by precharge, exactly two auto-refresh commands, and a mode register set on bank 0 with the DLL flag at 0.
- R7: Next comes extended mode set on bank 1 with calibration field 7, then the same command with calibration field 0, and last a normal-mode command (code 0). All commands other than the calibration-7 one carry calibration 0. All commands other than the first mode register set carry a DLL flag of 0. Non-mode commands carry bank 0.
- R8: One cycle after the normal-mode command is acknowledged, `init_done` is 1 and `busy` and `cmd_valid` are 0. `refresh_count` then equals round(TREFI_NS·CLK_FREQ_HZ/10^9), and `init_done` remains set until reset.
- R9: `start` while busy or after completion does not change the presented step or restart the sequence.
- R10: Reset during the sequence returns the block to idle with `init_done` clear. A later start begins again from the first no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins the sequence when idle |
| cmd_done | input | 1 | One-cycle acknowledge of the presented command |
| busy | output | 1 | Sequence in progress |
| cmd_valid | output | 1 | A command is presented |
| cmd_code | output | 3 | Command code |
| cmd_bank | output | 3 | Bank-address bits for the command |
| dll_reset | output | 1 | DLL-reset payload flag |
| ocd_mode | output | 3 | Off-chip-driver calibration field |
| init_done | output | 1 | Sequence complete |
| refresh_count | output | REF_W | Refresh interval in clock cycles, valid with init_done |

## Verification
The case hardest to reach from the ports is an acknowledge that arrives while the sequencer is counting a pause. A well-behaved command unit never sends one, yet the counter must neither shorten the pause nor skip a step when it happens. The bench injects `cmd_done` and `start` pulses deep inside the long pause, and still requires the measured pause length to match the rounded formula. The frequency parameter is set to a value whose cycle counts round upward, and each pause is measured cycle by cycle.

// File: rtl/ddr2i_pkg.sv
// Shared types for the DDR2 power-up sequencer.
// Assumes a single sequence of 16 steps; indices of the two pauses are fixed here.
package ddr2i_pkg;

    typedef enum logic [2:0] {
        CMD_NORMAL = 3'd0,
        CMD_NOP    = 3'd1,
        CMD_PRE    = 3'd2,
        CMD_MRS    = 3'd3,
        CMD_REF    = 3'd4,
        CMD_EMRS   = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        K_CMD        = 2'd0,
        K_WAIT_LONG  = 2'd1,
        K_WAIT_SHORT = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        cmd_e       cmd;
        logic [2:0] bank;
        logic       dll;
        logic [2:0] ocd;
    } step_t;

    localparam int STEP_W     = 4;
    localparam int IDX_LONG   = 1;
    localparam int IDX_SHORT  = 7;
    localparam int IDX_LAST   = 15;

endpackage

// File: rtl/ddr2i_step_table.sv
// Maps a step index to the command, bank and payload flags of that step.
// Assumes indices above IDX_LAST are never presented (they decode to normal mode).
module ddr2i_step_table
    import ddr2i_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    output step_t             entry
);

    // Decode the fixed power-up ordering.
    always_comb begin
        entry = '{kind: K_CMD, cmd: CMD_NORMAL, bank: 3'd0, dll: 1'b0, ocd: 3'd0};
        case (idx)
            4'd0:  entry.cmd  = CMD_NOP;
            4'd1:  entry.kind = K_WAIT_LONG;
            4'd2:  entry.cmd  = CMD_NOP;
            4'd3:  entry.cmd  = CMD_PRE;
            4'd4:  begin entry.cmd = CMD_EMRS; entry.bank = 3'd2; end
            4'd5:  begin entry.cmd = CMD_EMRS; entry.bank = 3'd3; end
            4'd6:  begin entry.cmd = CMD_EMRS; entry.bank = 3'd1; end
            4'd7:  entry.kind = K_WAIT_SHORT;
            4'd8:  begin entry.cmd = CMD_MRS; entry.dll = 1'b1; end
            4'd9:  entry.cmd  = CMD_PRE;
            4'd10: entry.cmd  = CMD_REF;
            4'd11: entry.cmd  = CMD_REF;
            4'd12: entry.cmd  = CMD_MRS;
            4'd13: begin entry.cmd = CMD_EMRS; entry.bank = 3'd1; entry.ocd = 3'd7; end
            4'd14: begin entry.cmd = CMD_EMRS; entry.bank = 3'd1; end
            default: entry.cmd = CMD_NORMAL;
        endcase
    end

endmodule

// File: rtl/ddr2i_delay_timer.sv
// Down-counter for the timed pauses: load sets the count, then it decrements to zero.
// Assumes load values of at least zero cycles remaining; expired is high at zero.
module ddr2i_delay_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 power-up sequencer: presents a fixed command list with two timed pauses,
// advancing one step per cmd_done, then raises init_done and the refresh interval.
// Assumes cmd_done is a single-cycle pulse from the command issue unit.
module ddr2_init_seq
    import ddr2i_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ = 50_000_000,
    parameter int unsigned PWRUP_US    = 200,
    parameter int unsigned DLL_US      = 2,
    parameter int unsigned TREFI_NS    = 7800,
    parameter int          REF_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmd_done,
    output logic             busy,
    output logic             cmd_valid,
    output logic [2:0]       cmd_code,
    output logic [2:0]       cmd_bank,
    output logic             dll_reset,
    output logic [2:0]       ocd_mode,
    output logic             init_done,
    output logic [REF_W-1:0] refresh_count
);

    localparam longint unsigned KHZ       = longint'(CLK_FREQ_HZ) / 1000;
    localparam longint unsigned LONG_RAW  = (KHZ * PWRUP_US + 500) / 1000;
    localparam longint unsigned SHORT_RAW = (KHZ * DLL_US + 500) / 1000;
    localparam longint unsigned LONG_CYC  = (LONG_RAW  < 1) ? 1 : LONG_RAW;
    localparam longint unsigned SHORT_CYC = (SHORT_RAW < 1) ? 1 : SHORT_RAW;
    localparam longint unsigned REF_CYC   =
        (longint'(TREFI_NS) * CLK_FREQ_HZ + 500_000_000) / 1_000_000_000;
    localparam int CNT_W = $clog2(LONG_CYC + 1);

    typedef enum logic [1:0] {S_IDLE, S_CMD, S_WAIT, S_DONE} state_e;

    state_e            state_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_nx;
    logic [REF_W-1:0]  ref_q;
    step_t             cur;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              nx_long;
    logic              nx_short;

    ddr2i_step_table u_table (
        .idx   (step_q),
        .entry (cur)
    );

    assign step_nx  = step_q + 4'd1;
    assign nx_long  = (step_nx == STEP_W'(IDX_LONG));
    assign nx_short = (step_nx == STEP_W'(IDX_SHORT));

    // Load the pause timer when an acknowledged command leads into a pause.
    always_comb begin
        tmr_load = (state_q == S_CMD) && cmd_done && (nx_long || nx_short);
        tmr_val  = nx_long ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
    end

    ddr2i_delay_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Sequence control: step through commands and pauses, finish with the refresh value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= '0;
            ref_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_CMD;
                    step_q  <= '0;
                end
                S_CMD: if (cmd_done) begin
                    if (step_q == STEP_W'(IDX_LAST)) begin
                        state_q <= S_DONE;
                        ref_q   <= REF_W'(REF_CYC);
                    end else begin
                        step_q  <= step_nx;
                        state_q <= (nx_long || nx_short) ? S_WAIT : S_CMD;
                    end
                end
                S_WAIT: if (tmr_expired) begin
                    step_q  <= step_nx;
                    state_q <= S_CMD;
                end
                default: state_q <= S_DONE;
            endcase
        end
    end

    assign busy          = (state_q == S_CMD) || (state_q == S_WAIT);
    assign cmd_valid     = (state_q == S_CMD);
    assign init_done     = (state_q == S_DONE);
    assign refresh_count = ref_q;
    assign cmd_code      = cur.cmd;
    assign cmd_bank      = cur.bank;
    assign dll_reset     = cur.dll;
    assign ocd_mode      = cur.ocd;

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_bank)
                                      && $stable(dll_reset) && $stable(ocd_mode)));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && start && !cmd_done) |=> $stable(step_q));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (!cmd_valid && !busy));

    assert_refresh_only_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_count != '0) |-> init_done);

endmodule

// File: tb/test_ddr2_init_seq.sv
// Bench: runs the full sequence with a frequency whose pause counts round upward,
// checks every command, measures the pauses, and covers start/reset corner cases.
module test_ddr2_init_seq;

    localparam int unsigned FREQ  = 33_333_333;
    localparam int unsigned TREFI = 7800;
    localparam int          RW    = 16;
    localparam longint EXP_LONG  = ((longint'(FREQ) / 1000) * 200 + 500) / 1000;
    localparam longint EXP_SHORT = ((longint'(FREQ) / 1000) * 2 + 500) / 1000;
    localparam longint EXP_REF   = (longint'(TREFI) * FREQ + 500_000_000) / 1_000_000_000;

    logic          clk = 1'b0;
    logic          rst_n, start, cmd_done;
    logic          busy, cmd_valid, dll_reset, init_done;
    logic [2:0]    cmd_code, cmd_bank, ocd_mode;
    logic [RW-1:0] refresh_count;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    ddr2_init_seq #(.CLK_FREQ_HZ(FREQ), .TREFI_NS(TREFI), .REF_W(RW)) i_ddr2_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_done(cmd_done),
        .busy(busy), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .dll_reset(dll_reset), .ocd_mode(ocd_mode), .init_done(init_done),
        .refresh_count(refresh_count)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected command k packed as {code, bank, dll, ocd}.
    function automatic logic [9:0] exp_cmd(input int k);
        case (k)
            0, 1:    return {3'd1, 3'd0, 1'b0, 3'd0};
            2, 7:    return {3'd2, 3'd0, 1'b0, 3'd0};
            3:       return {3'd5, 3'd2, 1'b0, 3'd0};
            4:       return {3'd5, 3'd3, 1'b0, 3'd0};
            5, 12:   return {3'd5, 3'd1, 1'b0, 3'd0};
            6:       return {3'd3, 3'd0, 1'b1, 3'd0};
            8, 9:    return {3'd4, 3'd0, 1'b0, 3'd0};
            10:      return {3'd3, 3'd0, 1'b0, 3'd0};
            11:      return {3'd5, 3'd1, 1'b0, 3'd7};
            default: return {3'd0, 3'd0, 1'b0, 3'd0};
        endcase
    endfunction

    function automatic string req_of(input int k);
        if (k == 0) return "R2";
        if (k == 1) return "R4";
        if (k <= 5) return "R5";
        if (k <= 10) return "R6";
        return "R7";
    endfunction

    // Check the presented command, then acknowledge it with a one-cycle pulse.
    task automatic take_cmd(input int k);
        chk(req_of(k), $sformatf("cmd %0d valid", k), cmd_valid, 1);
        chk(req_of(k), $sformatf("cmd %0d fields", k),
            {cmd_code, cmd_bank, dll_reset, ocd_mode}, exp_cmd(k));
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
    endtask

    // Count cycles with cmd_valid low; optionally inject stray done/start mid-pause.
    task automatic measure(input string req, input longint exp, input bit inject);
        longint n = 0;
        while (!cmd_valid && n < 20000) begin
            n++;
            if (inject && n == 5) begin cmd_done = 1'b1; start = 1'b1; end
            if (inject && n == 6) begin cmd_done = 1'b0; start = 1'b0; end
            @(negedge clk);
        end
        chk(req, "pause length", n, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 60000", cycles);
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; cmd_done = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "valid in reset", cmd_valid, 0);
        chk("R1", "done in reset", init_done, 0);
        chk("R1", "refresh in reset", refresh_count, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "idle without start", {busy, cmd_valid, init_done}, 0);

        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "busy after start", busy, 1);

        // R3: hold the first command several cycles without acknowledge
        repeat (3) @(negedge clk);
        chk("R3", "held command", {cmd_valid, cmd_code}, {1'b1, 3'd1});

        for (int k = 0; k < 14; k++) begin
            if (k == 3) begin
                start = 1'b1;            // R9: start while busy
                @(negedge clk);
                start = 1'b0;
                chk("R9", "step unchanged by start", {cmd_code, cmd_bank}, {3'd5, 3'd2});
            end
            take_cmd(k);
            if (k == 0) measure("R4", EXP_LONG, 1'b1);
            if (k == 5) measure("R5", EXP_SHORT, 1'b0);
        end

        chk("R8", "init_done", init_done, 1);
        chk("R8", "busy/valid after done", {busy, cmd_valid}, 0);
        chk("R8", "refresh count", refresh_count, EXP_REF);

        start = 1'b1;                    // R9: start after completion
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R9", "no restart after done", {init_done, cmd_valid, busy}, {1'b1, 1'b0, 1'b0});

        // R10: reset in the middle of a second run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10", "done cleared by reset", init_done, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        take_cmd(0);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10", "idle after mid reset", {busy, cmd_valid, init_done}, 0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10", "restart fields", {cmd_valid, cmd_code, cmd_bank}, {1'b1, 3'd1, 3'd0});

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule